// File: doc/BRIEF.md
# Highest-Priority Ready Task Resolver

This block helps a real-time kernel schedule tasks in hardware. It covers 64 task priorities. Priority 0 is the most urgent and 63 the least. The ready state is stored in two levels. One row register of 8 bits holds the ready tasks of each block of eight priorities, and a summary register holds one bit per row that says whether that row has any ready task. Software marks a task ready or not ready by giving its 6-bit priority on a set or a clear command.

When software pulses the schedule strobe, the block finds the most urgent ready task in two steps. First it picks the lowest-numbered non-empty row. Then it picks the lowest-numbered ready bit inside that row. It compares the result with the priority of the running task and tells software whether a context switch is needed. A switch is only requested when no interrupt handler is active and the scheduler is not locked. The block counts every switch it requests.

Top module: `hp_ready_resolver`

## Requirements
- R1: A set command with priority p sets bit p[2:0] of row p[5:3] and the summary bit p[5:3] at the next clock edge. When a set and a clear name the same priority in the same cycle, the task ends up ready.
- R2: A clear command with priority p clears bit p[2:0] of row p[5:3]. The summary bit p[5:3] is cleared only when that row has become all zero; other ready tasks in the same row stay ready.
- R3: The resolved priority is (r << 3) + b. Here r is the lowest-numbered set bit of the summary register and b is the lowest-numbered set bit of row r. This makes it the lowest ready priority number.
- R4: best_prio and best_valid are loaded at the clock edge that ends a cycle with sched_req high, and they hold between strobes. The state used is the ready state from before that edge, so set or clear commands in the same cycle are not seen.
- R5: When no task is ready, a strobe gives best_valid = 0 and best_prio = 0, and no switch is requested.
- R6: switch_req is high only in the cycle after a strobe during which isr_depth and lock_depth were both zero.
- R7: switch_req is high only when the resolved priority differs from cur_prio as sampled with the strobe. switch_req is a single-cycle pulse.
- R8: switch_count is CNT_W bits wide and goes up by one at the same edge that raises switch_req. It wraps modulo 2^CNT_W.
- R9: Synchronous active-high reset clears all ready state, best_prio, best_valid, switch_req and switch_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_en | input | 1 | Mark the task at set_prio ready |
| set_prio | input | 6 | Priority to mark ready |
| clr_en | input | 1 | Mark the task at clr_prio not ready |
| clr_prio | input | 6 | Priority to mark not ready |
| isr_depth | input | DEPTH_W (8) | Interrupt nesting count |
| lock_depth | input | DEPTH_W (8) | Scheduler lock count |
| cur_prio | input | 6 | Priority of the running task |
| sched_req | input | 1 | Schedule strobe |
| best_prio | output | 6 | Registered resolved priority |
| best_valid | output | 1 | At least one task was ready at the last strobe |
| switch_req | output | 1 | One-cycle context switch request |
| switch_count | output | CNT_W (32) | Number of switches requested |

## Verification
Directed patterns cover each distinct behaviour:
- A lone task at priority 63 checks the far corner of both lookup levels.
- Two tasks in the same row check which bit wins inside a row.
- Clearing one of them checks that the summary bit survives while its row is still non-empty.
- A same-cycle set and clear of one priority checks which command wins.
- A same-cycle strobe and clear checks that the resolver uses the pre-edge state.
- Strobes with non-zero nesting or lock counts check the gating.
- A strobe where cur_prio equals the winner checks the equality case.
- A strobe with nothing ready checks the empty case.

Seeded random traffic then covers many mixes of occupancy, gating and cur_prio. A 4-bit counter instance runs beside the main one on the same inputs and shows the wrap.

// File: rtl/resolver_pkg.sv
package resolver_pkg;

    localparam int GRP_BITS = 3;
    localparam int BIT_BITS = 3;
    localparam int PRIO_W   = GRP_BITS + BIT_BITS;
    localparam int NGRP     = 1 << GRP_BITS;
    localparam int ROW_W    = 1 << BIT_BITS;
    localparam int NREADY   = NGRP * ROW_W;

    typedef struct packed {
        logic              valid;
        logic [PRIO_W-1:0] prio;
    } prio_cmd_t;

    typedef struct packed {
        logic              valid;
        logic [PRIO_W-1:0] prio;
    } hp_result_t;

    function automatic logic [GRP_BITS-1:0] row_of(input logic [PRIO_W-1:0] p);
        return p[PRIO_W-1:BIT_BITS];
    endfunction

    function automatic logic [BIT_BITS-1:0] col_of(input logic [PRIO_W-1:0] p);
        return p[BIT_BITS-1:0];
    endfunction

endpackage

// File: rtl/ready_table.sv
module ready_table
    import resolver_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  prio_cmd_t                      set_cmd,
    input  prio_cmd_t                      clr_cmd,
    output logic [NGRP-1:0]                grp_q,
    output logic [NGRP-1:0][ROW_W-1:0]     rows_q
);

    logic [NREADY-1:0] flat;
    assign flat = rows_q;

    for (genvar g = 0; g < NGRP; g++) begin : g_row
        logic [ROW_W-1:0] row_nx;

        always_comb begin
            row_nx = rows_q[g];
            if (clr_cmd.valid && row_of(clr_cmd.prio) == GRP_BITS'(g))
                row_nx[col_of(clr_cmd.prio)] = 1'b0;
            if (set_cmd.valid && row_of(set_cmd.prio) == GRP_BITS'(g))
                row_nx[col_of(set_cmd.prio)] = 1'b1;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                rows_q[g] <= '0;
                grp_q[g]  <= 1'b0;
            end else begin
                rows_q[g] <= row_nx;
                grp_q[g]  <= |row_nx;
            end
        end

        // R2: summary bit tracks row occupancy
        assert_group_matches_row_R2: assert property (@(posedge clk) disable iff (rst)
            grp_q[g] == (|rows_q[g]));
    end

    assert_set_marks_R1: assert property (@(posedge clk) disable iff (rst)
        set_cmd.valid |=> flat[$past(set_cmd.prio)]);

    assert_clear_drops_R2: assert property (@(posedge clk) disable iff (rst)
        (clr_cmd.valid && !(set_cmd.valid && set_cmd.prio == clr_cmd.prio))
        |=> !flat[$past(clr_cmd.prio)]);

endmodule

// File: rtl/lsb_finder.sv
module lsb_finder #(
    parameter int W  = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);

    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    assign any = |vec;

endmodule

// File: rtl/switch_decider.sv
module switch_decider
    import resolver_pkg::*;
#(
    parameter int DEPTH_W = 8,
    parameter int CNT_W   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sched_req,
    input  logic [DEPTH_W-1:0] isr_depth,
    input  logic [DEPTH_W-1:0] lock_depth,
    input  logic [PRIO_W-1:0]  cur_prio,
    input  hp_result_t         cand,
    output hp_result_t         result_q,
    output logic               switch_q,
    output logic [CNT_W-1:0]   count_q
);

    logic idle_ok;
    logic go;

    assign idle_ok = (isr_depth == '0) && (lock_depth == '0);
    assign go      = sched_req && idle_ok && cand.valid && (cand.prio != cur_prio);

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            switch_q <= 1'b0;
            count_q  <= '0;
        end else begin
            if (sched_req) result_q <= cand;
            switch_q <= go;
            if (go) count_q <= count_q + 1'b1;
        end
    end

    assert_switch_gated_R6: assert property (@(posedge clk) disable iff (rst)
        switch_q |-> $past(sched_req) && $past(isr_depth) == '0 && $past(lock_depth) == '0);

    assert_switch_differs_R7: assert property (@(posedge clk) disable iff (rst)
        switch_q |-> result_q.valid && result_q.prio != $past(cur_prio));

    assert_empty_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !result_q.valid |-> !switch_q && result_q.prio == '0);

    assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
        switch_q |-> count_q == $past(count_q) + 1'b1);

    assert_count_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !switch_q |-> $stable(count_q));

endmodule

// File: rtl/hp_ready_resolver.sv
module hp_ready_resolver
    import resolver_pkg::*;
#(
    parameter int DEPTH_W = 8,
    parameter int CNT_W   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               set_en,
    input  logic [PRIO_W-1:0]  set_prio,
    input  logic               clr_en,
    input  logic [PRIO_W-1:0]  clr_prio,
    input  logic [DEPTH_W-1:0] isr_depth,
    input  logic [DEPTH_W-1:0] lock_depth,
    input  logic [PRIO_W-1:0]  cur_prio,
    input  logic               sched_req,
    output logic [PRIO_W-1:0]  best_prio,
    output logic               best_valid,
    output logic               switch_req,
    output logic [CNT_W-1:0]   switch_count
);

    prio_cmd_t                   set_cmd, clr_cmd;
    logic [NGRP-1:0]             grp_q;
    logic [NGRP-1:0][ROW_W-1:0]  rows_q;
    logic [GRP_BITS-1:0]         grp_idx;
    logic                        grp_any;
    logic [BIT_BITS-1:0]         col_idx;
    logic                        col_any;
    hp_result_t                  cand;
    hp_result_t                  result_q;
    logic [NREADY-1:0]           flat;

    assign set_cmd = '{valid: set_en, prio: set_prio};
    assign clr_cmd = '{valid: clr_en, prio: clr_prio};

    ready_table u_table (
        .clk    (clk),
        .rst    (rst),
        .set_cmd(set_cmd),
        .clr_cmd(clr_cmd),
        .grp_q  (grp_q),
        .rows_q (rows_q)
    );

    lsb_finder #(.W(NGRP)) u_grp_find (
        .vec(grp_q),
        .idx(grp_idx),
        .any(grp_any)
    );

    lsb_finder #(.W(ROW_W)) u_col_find (
        .vec(rows_q[grp_idx]),
        .idx(col_idx),
        .any(col_any)
    );

    assign cand.valid = grp_any;
    assign cand.prio  = {grp_idx, col_idx};
    assign flat       = rows_q;

    switch_decider #(.DEPTH_W(DEPTH_W), .CNT_W(CNT_W)) u_decide (
        .clk       (clk),
        .rst       (rst),
        .sched_req (sched_req),
        .isr_depth (isr_depth),
        .lock_depth(lock_depth),
        .cur_prio  (cur_prio),
        .cand      (cand),
        .result_q  (result_q),
        .switch_q  (switch_req),
        .count_q   (switch_count)
    );

    assign best_prio  = result_q.prio;
    assign best_valid = result_q.valid;

    // R3: the chosen priority is ready and no lower number is ready
    assert_winner_ready_R3: assert property (@(posedge clk) disable iff (rst)
        cand.valid |-> flat[cand.prio] && col_any);

    assert_winner_lowest_R3: assert property (@(posedge clk) disable iff (rst)
        cand.valid |-> (flat & ~({NREADY{1'b1}} << cand.prio)) == '0);

    assert_empty_table_R5: assert property (@(posedge clk) disable iff (rst)
        !cand.valid |-> flat == '0);

endmodule

// File: tb/tb_hp_ready_resolver.sv
module tb_hp_ready_resolver;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       set_en, clr_en, sched_req;
    logic [5:0] set_prio, clr_prio, cur_prio;
    logic [7:0] isr_depth, lock_depth;
    logic [5:0] best_prio, n_best_prio;
    logic       best_valid, switch_req, n_best_valid, n_switch_req;
    logic [31:0] switch_count;
    logic [3:0]  n_switch_count;

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [63:0] model;
    logic        exp_valid, exp_sw;
    logic [5:0]  exp_best;
    logic [31:0] exp_cnt;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hp_ready_resolver dut (
        .clk(clk), .rst(rst), .set_en(set_en), .set_prio(set_prio),
        .clr_en(clr_en), .clr_prio(clr_prio), .isr_depth(isr_depth),
        .lock_depth(lock_depth), .cur_prio(cur_prio), .sched_req(sched_req),
        .best_prio(best_prio), .best_valid(best_valid),
        .switch_req(switch_req), .switch_count(switch_count)
    );

    hp_ready_resolver #(.CNT_W(4)) dut_narrow (
        .clk(clk), .rst(rst), .set_en(set_en), .set_prio(set_prio),
        .clr_en(clr_en), .clr_prio(clr_prio), .isr_depth(isr_depth),
        .lock_depth(lock_depth), .cur_prio(cur_prio), .sched_req(sched_req),
        .best_prio(n_best_prio), .best_valid(n_best_valid),
        .switch_req(n_switch_req), .switch_count(n_switch_count)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] lowest(input logic [63:0] m);
        for (int i = 0; i < 64; i++)
            if (m[i]) return {1'b1, 6'(i)};
        return 7'd0;
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic step(input logic sv, input logic [5:0] sp, input logic cv,
                        input logic [5:0] cp, input logic [7:0] isr, input logic [7:0] lk,
                        input logic [5:0] cur, input logic sr, input string tag);
        logic [6:0] lo;
        set_en = sv; set_prio = sp; clr_en = cv; clr_prio = cp;
        isr_depth = isr; lock_depth = lk; cur_prio = cur; sched_req = sr;
        exp_sw = 1'b0;
        if (sr) begin
            lo        = lowest(model);
            exp_valid = lo[6];
            exp_best  = lo[5:0];
            exp_sw    = exp_valid && isr == 0 && lk == 0 && exp_best != cur;
        end
        if (exp_sw) exp_cnt = exp_cnt + 1;
        if (cv) model[cp] = 1'b0;
        if (sv) model[sp] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk({tag, " best_valid"}, 32'(best_valid), 32'(exp_valid));
        chk({tag, " best_prio"}, 32'(best_prio), 32'(exp_best));
        chk({tag, " switch_req"}, 32'(switch_req), 32'(exp_sw));
        chk({tag, " switch_count"}, switch_count, exp_cnt);
        chk({tag, " R8 narrow wrap"}, 32'(n_switch_count), 32'(exp_cnt[3:0]));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1;
        set_en = 0; clr_en = 0; sched_req = 0;
        set_prio = 0; clr_prio = 0; cur_prio = 0; isr_depth = 0; lock_depth = 0;
        model = '0; exp_valid = 0; exp_best = 0; exp_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset best_valid", 32'(best_valid), 0);
        chk("R9 reset best_prio", 32'(best_prio), 0);
        chk("R9 reset switch_req", 32'(switch_req), 0);
        chk("R9 reset switch_count", switch_count, 0);
        rst = 1'b0;

        step(0, 0, 0, 0, 0, 0, 0, 1, "R5 empty");
        step(1, 63, 0, 0, 0, 0, 0, 0, "R1 set 63");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R3 lone 63");
        step(1, 14, 0, 0, 0, 0, 0, 0, "R1 set 14");
        step(1, 9, 0, 0, 0, 0, 0, 0, "R1 set 9");
        step(0, 0, 0, 0, 0, 0, 9, 1, "R7 equal current");
        step(0, 0, 1, 9, 0, 0, 0, 1, "R4 pre-edge state");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R2 row kept");
        step(1, 5, 1, 5, 0, 0, 0, 0, "R1 set wins");
        step(0, 0, 0, 0, 0, 0, 63, 1, "R1 set wins result");
        step(0, 0, 0, 0, 1, 0, 63, 1, "R6 isr gate");
        step(0, 0, 0, 0, 0, 2, 63, 1, "R6 lock gate");
        step(0, 0, 1, 5, 0, 0, 0, 0, "R2 clear 5");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R4 hold");
        step(0, 0, 1, 14, 0, 0, 0, 0, "R2 clear 14");
        step(0, 0, 1, 63, 0, 0, 0, 0, "R2 clear 63");
        step(0, 0, 0, 0, 0, 0, 7, 1, "R5 empty again");

        for (int k = 0; k < 3000; k++) begin
            logic [7:0] isr_r, lk_r;
            isr_r = ($urandom % 4 == 0) ? 8'($urandom % 3) : 8'd0;
            lk_r  = ($urandom % 4 == 0) ? 8'($urandom % 3) : 8'd0;
            step(1'($urandom % 2), 6'($urandom), 1'($urandom % 3 == 0), 6'($urandom),
                 isr_r, lk_r, 6'($urandom), 1'($urandom % 2),
                 "R3 R6 R7 R8 random");
        end

        done = 1;
        summary();
        $finish;
    end

endmodule